// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a word-wide register datapath and a byte-addressed data memory that is one word wide. It has two independent paths. The store path takes a register value, an access size and the low address bits. It returns write data copied across the byte lanes, together with a per-lane byte-enable mask. With this data the memory needs no shifter of its own: the enables alone choose which bytes change. The load path takes the raw memory word, the access size, a signed/unsigned select and the low address bits. It returns the addressed byte, halfword or word, moved down to bit 0 and then sign- or zero-extended to the full datapath width.

The effective address is formed elsewhere as a base register plus a signed 16-bit displacement, and only its low bits arrive here. Lane order is little-endian. An access whose size does not fit its address raises a misalignment flag. Such an access gets no byte enables and a zero load value. Trapping on the flag is left to the surrounding pipeline. A parameter selects a registered output stage with one cycle of latency, or purely combinational outputs.

Top module: `lsu_lane_aligner`

## Requirements
- R1: Store byte enables are a single lane for a byte (enable bit equal to the address offset), two adjacent lanes for a halfword (offset and offset+1), and every lane for a word. Size codes are 0 = byte, 1 = half, 2 = word and 3 = reserved.
- R2: Store write data holds value bits 7:0 in every byte lane for a byte access, value bits 15:0 in every halfword slot for a half access, and the unchanged value for a word or reserved access.
- R3: Loads are little-endian: offset k selects memory bits 8k+7:8k as the low byte, and a word load returns the memory word unchanged whatever the signed select.
- R4: A byte or halfword load with the signed select at 1 fills every upper result bit with the top bit of the extracted field.
- R5: A byte or halfword load with the signed select at 0 fills every upper result bit with zero.
- R6: A halfword access with address bit 0 set, or a word access with any nonzero offset, raises the misalignment flag of its path. The store path then drives all byte enables to 0, and the load path returns 0.
- R7: The reserved size code 3 always raises the misalignment flag, gives no byte enables and a zero load value.
- R8: With REG_OUT = 1 every output follows its inputs one clock later and is cleared to zero while rst_n is low. With REG_OUT = 0 the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| st_size | input | 2 | Store access size code |
| st_ofs | input | OFS_W | Low address bits of the store |
| st_value | input | DATA_W | Register value to be stored |
| st_wdata | output | DATA_W | Lane-replicated write data |
| st_be | output | LANES | Byte enable per lane |
| st_misalign | output | 1 | Store size/address mismatch |
| ld_size | input | 2 | Load access size code |
| ld_signed | input | 1 | 1 = sign-extend sub-word loads |
| ld_ofs | input | OFS_W | Low address bits of the load |
| ld_word | input | DATA_W | Raw word read from memory |
| ld_value | output | DATA_W | Extracted and extended load result |
| ld_misalign | output | 1 | Load size/address mismatch |

## Verification
The assertions assume that the size codes, offsets and data inputs are known (not X) at every rising edge while reset is released, and that they are stable around that edge. The property on the registered stage also assumes that the clock runs without gaps after reset. The bench changes inputs only on falling edges and drives fully defined values, including the reserved size code. It steps through every size, offset and signed-select combination before moving to random words, so each assumed input stays inside the legal set.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned HALF_BITS = 16;
endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
   import lsu_align_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned OFS_W = 2
) (
   input  acc_size_e        size,
   input  logic [OFS_W-1:0] ofs,
   output logic [LANES-1:0] be,
   output logic             misalign
);
   localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
   localparam logic [LANES-1:0] TWO_LANE = LANES'(3);

   logic [LANES-1:0] raw;

   always_comb begin
      unique case (size)
         SZ_BYTE: misalign = 1'b0;
         SZ_HALF: misalign = ofs[0];
         SZ_WORD: misalign = (ofs != '0);
         default: misalign = 1'b1;
      endcase
   end

   always_comb begin
      unique case (size)
         SZ_BYTE: raw = ONE_LANE << ofs;
         SZ_HALF: raw = TWO_LANE << ofs;
         SZ_WORD: raw = '1;
         default: raw = '0;
      endcase
      be = misalign ? '0 : raw;
   end
endmodule

// File: rtl/store_replicator.sv
module store_replicator
   import lsu_align_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  acc_size_e         size,
   input  logic [DATA_W-1:0] value,
   output logic [DATA_W-1:0] wdata
);
   localparam int unsigned LANES = DATA_W / BYTE_BITS;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [BYTE_BITS-1:0] lane_q;
      always_comb begin
         unique case (size)
            SZ_BYTE: lane_q = value[BYTE_BITS-1:0];
            SZ_HALF: lane_q = value[(i % 2)*BYTE_BITS +: BYTE_BITS];
            default: lane_q = value[i*BYTE_BITS +: BYTE_BITS];
         endcase
      end
      assign wdata[i*BYTE_BITS +: BYTE_BITS] = lane_q;
   end
endmodule

// File: rtl/load_extractor.sv
module load_extractor
   import lsu_align_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OFS_W  = 2
) (
   input  acc_size_e         size,
   input  logic              sext,
   input  logic [OFS_W-1:0]  ofs,
   input  logic              misalign,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] value
);
   logic [DATA_W-1:0] shifted;
   logic              fill_b;
   logic              fill_h;

   assign shifted = word >> {ofs, 3'b000};
   assign fill_b  = sext & shifted[BYTE_BITS-1];
   assign fill_h  = sext & shifted[HALF_BITS-1];

   always_comb begin
      if (misalign) begin
         value = '0;
      end else begin
         unique case (size)
            SZ_BYTE: value = {{(DATA_W-BYTE_BITS){fill_b}}, shifted[BYTE_BITS-1:0]};
            SZ_HALF: value = {{(DATA_W-HALF_BITS){fill_h}}, shifted[HALF_BITS-1:0]};
            default: value = word;
         endcase
      end
   end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
   import lsu_align_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned REG_OUT = 1,
   localparam int unsigned LANES  = DATA_W / 8,
   localparam int unsigned OFS_W  = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        st_size,
   input  logic [OFS_W-1:0]  st_ofs,
   input  logic [DATA_W-1:0] st_value,
   output logic [DATA_W-1:0] st_wdata,
   output logic [LANES-1:0]  st_be,
   output logic              st_misalign,
   input  logic [1:0]        ld_size,
   input  logic              ld_signed,
   input  logic [OFS_W-1:0]  ld_ofs,
   input  logic [DATA_W-1:0] ld_word,
   output logic [DATA_W-1:0] ld_value,
   output logic              ld_misalign
);
   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("lsu_lane_aligner: DATA_W must be a power of two of at least 32");
   end
   if (REG_OUT > 1) begin : g_bad_reg
      $error("lsu_lane_aligner: REG_OUT must be 0 or 1");
   end

   acc_size_e st_sz, ld_sz;
   assign st_sz = acc_size_e'(st_size);
   assign ld_sz = acc_size_e'(ld_size);

   logic [DATA_W-1:0] st_wdata_c, ld_value_c;
   logic [LANES-1:0]  st_be_c, ld_be_unused;
   logic              st_mis_c, ld_mis_c;

   lane_mask_gen #(.LANES(LANES), .OFS_W(OFS_W)) u_st_mask (
      .size(st_sz), .ofs(st_ofs), .be(st_be_c), .misalign(st_mis_c));

   lane_mask_gen #(.LANES(LANES), .OFS_W(OFS_W)) u_ld_mask (
      .size(ld_sz), .ofs(ld_ofs), .be(ld_be_unused), .misalign(ld_mis_c));

   store_replicator #(.DATA_W(DATA_W)) u_st_rep (
      .size(st_sz), .value(st_value), .wdata(st_wdata_c));

   load_extractor #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_ld_ext (
      .size(ld_sz), .sext(ld_signed), .ofs(ld_ofs), .misalign(ld_mis_c),
      .word(ld_word), .value(ld_value_c));

   if (REG_OUT == 1) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_wdata    <= '0;
            st_be       <= '0;
            st_misalign <= 1'b0;
            ld_value    <= '0;
            ld_misalign <= 1'b0;
         end else begin
            st_wdata    <= st_wdata_c;
            st_be       <= st_be_c;
            st_misalign <= st_mis_c;
            ld_value    <= ld_value_c;
            ld_misalign <= ld_mis_c;
         end
      end

      // R8: registered stage carries the mask and flag one cycle later
      a_r8_be_latency: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (st_be == $past(st_be_c)) && (ld_misalign == $past(ld_mis_c)));
   end else begin : g_comb_out
      assign st_wdata    = st_wdata_c;
      assign st_be       = st_be_c;
      assign st_misalign = st_mis_c;
      assign ld_value    = ld_value_c;
      assign ld_misalign = ld_mis_c;
   end

   a_r6_misalign_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
      st_mis_c |-> (st_be_c == '0));

   a_r1_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (st_sz == SZ_BYTE) |-> ($countones(st_be_c) == 1));

   a_r1_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (st_sz == SZ_HALF && !st_ofs[0]) |-> ($countones(st_be_c) == 2));

   a_r7_reserved_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (st_sz == SZ_RSVD) |-> (st_mis_c && st_be_c == '0));

   a_r5_byte_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_sz == SZ_BYTE && !ld_signed) |-> (ld_value_c[DATA_W-1:8] == '0));

   a_r4_byte_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_sz == SZ_BYTE && ld_signed) |->
         (ld_value_c[DATA_W-1:8] == {(DATA_W-8){ld_value_c[7]}}));

   a_r6_load_zero_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
      ld_mis_c |-> (ld_value_c == '0));
endmodule

// File: tb/sim_lsu_lane_aligner.sv
module sim_lsu_lane_aligner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  st_size = '0, ld_size = '0;
   logic [1:0]  st_ofs = '0, ld_ofs = '0;
   logic        ld_signed = 1'b0;
   logic [31:0] st_value = '0, ld_word = '0;
   logic [31:0] st_wdata, ld_value;
   logic [3:0]  st_be;
   logic        st_misalign, ld_misalign;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   typedef struct {
      logic [31:0] wdata;
      logic [3:0]  be;
      logic        smis;
      logic [31:0] lval;
      logic        lmis;
      logic [1:0]  ssz;
      logic [1:0]  lsz;
      logic        lsg;
   } exp_t;
   exp_t pend[$];

   always #5 clk = ~clk;

   lsu_lane_aligner u0 (
      .clk(clk), .rst_n(rst_n),
      .st_size(st_size), .st_ofs(st_ofs), .st_value(st_value),
      .st_wdata(st_wdata), .st_be(st_be), .st_misalign(st_misalign),
      .ld_size(ld_size), .ld_signed(ld_signed), .ld_ofs(ld_ofs),
      .ld_word(ld_word), .ld_value(ld_value), .ld_misalign(ld_misalign));

   function automatic bit is_mis(input logic [1:0] sz, input logic [1:0] a);
      if (sz == 2'd3) return 1;
      if (sz == 2'd1) return a[0];
      if (sz == 2'd2) return a != 0;
      return 0;
   endfunction

   function automatic exp_t model(input logic [1:0] ssz, input logic [1:0] sa,
                                  input logic [31:0] sv, input logic [1:0] lsz,
                                  input logic sg, input logic [1:0] la,
                                  input logic [31:0] lw);
      exp_t e;
      int sh;
      logic [31:0] f;
      e.ssz = ssz; e.lsz = lsz; e.lsg = sg;
      e.smis = is_mis(ssz, sa);
      e.lmis = is_mis(lsz, la);
      if (ssz == 0)      e.wdata = {4{sv[7:0]}};
      else if (ssz == 1) e.wdata = {2{sv[15:0]}};
      else               e.wdata = sv;
      if (e.smis)        e.be = 4'b0000;
      else if (ssz == 0) e.be = 4'b0001 << sa;
      else if (ssz == 1) e.be = 4'b0011 << sa;
      else               e.be = 4'b1111;
      sh = 8 * int'(la);
      f  = lw >> sh;
      if (e.lmis)        e.lval = 0;
      else if (lsz == 0) e.lval = (sg && f[7])  ? (f | 32'hFFFF_FF00) : (f & 32'h0000_00FF);
      else if (lsz == 1) e.lval = (sg && f[15]) ? (f | 32'hFFFF_0000) : (f & 32'h0000_FFFF);
      else               e.lval = lw;
      return e;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   task automatic compare(input exp_t e);
      string lr;
      check(e.ssz == 3 ? "R7" : (e.smis ? "R6" : "R1"), "st_be", {28'd0, st_be}, {28'd0, e.be});
      check("R2", "st_wdata", st_wdata, e.wdata);
      check(e.ssz == 3 ? "R7" : "R6", "st_misalign", {31'd0, st_misalign}, {31'd0, e.smis});
      check(e.lsz == 3 ? "R7" : "R6", "ld_misalign", {31'd0, ld_misalign}, {31'd0, e.lmis});
      if (e.lsz == 3)     lr = "R7";
      else if (e.lmis)    lr = "R6";
      else if (e.lsz == 2) lr = "R3";
      else if (e.lsg)     lr = "R4";
      else                lr = "R5";
      check(lr, "ld_value", ld_value, e.lval);
   endtask

   // one step: compare the previous cycle's expectation, then drive new inputs
   task automatic step(input logic [1:0] ssz, input logic [1:0] sa, input logic [31:0] sv,
                       input logic [1:0] lsz, input logic sg, input logic [1:0] la,
                       input logic [31:0] lw);
      @(negedge clk);
      if (pend.size() > 0) compare(pend.pop_front());
      st_size = ssz; st_ofs = sa; st_value = sv;
      ld_size = lsz; ld_signed = sg; ld_ofs = la; ld_word = lw;
      pend.push_back(model(ssz, sa, sv, lsz, sg, la, lw));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      // R8: reset clears outputs even with live inputs
      st_size = 2'd2; st_value = 32'hDEAD_BEEF; ld_size = 2'd2; ld_word = 32'h1234_5678;
      repeat (3) @(negedge clk);
      check("R8", "reset st_wdata", st_wdata, 32'h0);
      check("R8", "reset st_be", {28'd0, st_be}, 32'h0);
      check("R8", "reset ld_value", ld_value, 32'h0);
      check("R8", "reset flags", {30'd0, st_misalign, ld_misalign}, 32'h0);
      rst_n = 1'b1;

      // R8: output holds until the next rising edge
      @(negedge clk);
      st_size = 2'd0; st_ofs = 2'd3; st_value = 32'h0000_00A5;
      ld_size = 2'd0; ld_signed = 1'b1; ld_ofs = 2'd3; ld_word = 32'h8000_0000;
      #1;
      check("R8", "latency st_be before edge", {28'd0, st_be}, {28'd0, 4'b1111});
      pend.push_back(model(2'd0, 2'd3, 32'h0000_00A5, 2'd0, 1'b1, 2'd3, 32'h8000_0000));

      // exhaustive corners: every size, offset and sign select
      for (int sz = 0; sz < 4; sz++)
         for (int a = 0; a < 4; a++)
            for (int sg = 0; sg < 2; sg++) begin
               step(2'(sz), 2'(a), 32'hC3B2_A190, 2'(sz), 1'(sg), 2'(a), 32'h80FF_7F01);
               step(2'(sz), 2'(a), 32'h1357_9BDF, 2'(sz), 1'(sg), 2'(a), 32'h7F80_01FF);
            end

      // random traffic
      for (int n = 0; n < 3000; n++)
         step(2'($urandom), 2'($urandom), $urandom, 2'($urandom), 1'($urandom),
              2'($urandom), $urandom);

      @(negedge clk);
      if (pend.size() > 0) compare(pend.pop_front());
      summary();
   end
endmodule